// File: doc/BRIEF.md
# Mixed-Format Fixed-Point Adder

This block adds two fixed-point operands that need not share a format. Each operand has its own total width and its own count of fractional bits. One parameter sets whether both operands are read as unsigned or as two's complement. The block is purely combinational. It brings both operands to a common format: the binary points line up, the fractional parts have the larger fractional count, and the integer parts have the larger integer count. It then adds the two aligned words in one shared binary adder.

A compile-time policy sets how the result is formed:

- **Wrap** keeps the common width and discards any overflow.
- **Grow** adds one integer bit, so the sum is always exact.
- **Detect** keeps the common width and raises a flag when the true sum does not fit.

The fractional bit count of the result is published as a localparam. Logic downstream can use it to keep track of where the binary point sits.

Top module: `fxadd_mixed`

## Requirements
- R1: The operand with fewer fractional bits is shifted up by the difference, with zeros filled in below its LSB. One LSB of that operand therefore carries a weight of 2^(FRAC-F) result LSBs, where FRAC is the larger fractional count.
- R2: The operand with fewer integer bits is extended at the MSB. The fill is zeros when SIGNED is 0 and copies of its sign bit when SIGNED is 1.
- R3: With MODE = 1 (grow), the result is AW+1 bits wide and equals the exact sum of the aligned operands. AW is the larger integer count plus FRAC. The result is signed or unsigned to match SIGNED.
- R4: With MODE = 0 (wrap), the result is AW bits wide and equals the exact aligned sum modulo 2^AW.
- R5: With MODE = 2 (detect) and SIGNED = 0, the result is the AW-bit wrapped sum. The flag is 1 exactly when the carry out of the MSB is set, which means the exact sum is 2^AW or more.
- R6: With MODE = 2 (detect) and SIGNED = 1, the result is the AW-bit wrapped sum. The flag is 1 exactly when both aligned operands have the same sign and the sign of the result differs from it.
- R7: In wrap mode and in grow mode the flag is always 0.
- R8: The result has FRAC fractional bits, where FRAC is the larger of the two input fractional counts. The width of the result port follows from R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | A_W | First operand, A_F fractional bits |
| b_i | input | B_W | Second operand, B_F fractional bits |
| sum_o | output | OUT_W | Sum, FRAC fractional bits (AW bits, or AW+1 in grow mode) |
| ovf_o | output | 1 | Overflow flag, active only in detect mode |

## Verification
The block holds no state, so every result and flag is due within the cycle in which its operands change. The bench drives new operands just after a rising edge and reads all outputs at the following falling edge, once the logic has settled. Five instances that differ only in policy and signedness share the same operands, so each vector is checked against every rule in the same half cycle.

// File: rtl/fxadd_pkg.sv
package fxadd_pkg;

    typedef enum logic [1:0] {
        ADD_WRAP   = 2'd0,
        ADD_GROW   = 2'd1,
        ADD_DETECT = 2'd2
    } add_mode_e;

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    function automatic int out_width(input int aw, input add_mode_e m);
        return (m == ADD_GROW) ? aw + 1 : aw;
    endfunction

endpackage

// File: rtl/fxadd_align.sv
module fxadd_align #(
    parameter int W_IN     = 8,
    parameter int F_IN     = 3,
    parameter int INT_OUT  = 5,
    parameter int FRAC_OUT = 4,
    parameter bit SGN      = 1'b1
) (
    input  logic [W_IN-1:0]             din,
    output logic [INT_OUT+FRAC_OUT-1:0] dout
);
    localparam int W_OUT = INT_OUT + FRAC_OUT;
    localparam int PAD_L = FRAC_OUT - F_IN;

    logic [W_OUT-1:0] widened;

    generate
        if (SGN) begin : g_sext
            assign widened = W_OUT'($signed(din));
        end else begin : g_zext
            assign widened = W_OUT'(din);
        end
    endgenerate

    assign dout = widened << PAD_L;
endmodule

// File: rtl/fxadd_core.sv
module fxadd_core #(
    parameter int W   = 9,
    parameter bit SGN = 1'b1
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W:0]   s
);
    logic xh, yh;

    generate
        if (SGN) begin : g_sgn
            assign xh = x[W-1];
            assign yh = y[W-1];
        end else begin : g_uns
            assign xh = 1'b0;
            assign yh = 1'b0;
        end
    endgenerate

    assign s = {xh, x} + {yh, y};
endmodule

// File: rtl/fxadd_ovf.sv
module fxadd_ovf #(
    parameter int                  W    = 9,
    parameter bit                  SGN  = 1'b1,
    parameter fxadd_pkg::add_mode_e MODE = fxadd_pkg::ADD_DETECT
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W:0]   s,
    output logic         ovf
);
    generate
        if (MODE != fxadd_pkg::ADD_DETECT) begin : g_off
            assign ovf = 1'b0;
        end else if (SGN) begin : g_sgn
            assign ovf = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
        end else begin : g_uns
            assign ovf = s[W];
        end
    endgenerate
endmodule

// File: rtl/fxadd_mixed.sv
module fxadd_mixed
    import fxadd_pkg::*;
#(
    parameter int        A_W    = 8,
    parameter int        A_F    = 3,
    parameter int        B_W    = 6,
    parameter int        B_F    = 4,
    parameter bit        SIGNED = 1'b1,
    parameter add_mode_e MODE   = ADD_GROW,
    localparam int FRAC  = imax(A_F, B_F),
    localparam int INTB  = imax(A_W - A_F, B_W - B_F),
    localparam int AW    = INTB + FRAC,
    localparam int OUT_W = out_width(AW, MODE)
) (
    input  logic [A_W-1:0]   a_i,
    input  logic [B_W-1:0]   b_i,
    output logic [OUT_W-1:0] sum_o,
    output logic             ovf_o
);
    logic [AW-1:0] a_al, b_al;
    logic [AW:0]   s_ext;

    fxadd_align #(.W_IN(A_W), .F_IN(A_F), .INT_OUT(INTB), .FRAC_OUT(FRAC), .SGN(SIGNED))
        u_align_a (.din(a_i), .dout(a_al));
    fxadd_align #(.W_IN(B_W), .F_IN(B_F), .INT_OUT(INTB), .FRAC_OUT(FRAC), .SGN(SIGNED))
        u_align_b (.din(b_i), .dout(b_al));

    fxadd_core #(.W(AW), .SGN(SIGNED)) u_core (.x(a_al), .y(b_al), .s(s_ext));

    fxadd_ovf #(.W(AW), .SGN(SIGNED), .MODE(MODE))
        u_ovf (.x(a_al), .y(b_al), .s(s_ext), .ovf(ovf_o));

    generate
        if (MODE == ADD_GROW) begin : g_grow
            assign sum_o = s_ext;
        end else begin : g_keep
            assign sum_o = s_ext[AW-1:0];
        end
    endgenerate

    always_comb begin
        // R1: low bits that were added by the alignment carry no value
        if (A_F < FRAC) a_r1_pad_a: assert (a_al[0] == 1'b0);
        if (B_F < FRAC) a_r1_pad_b: assert (b_al[0] == 1'b0);
        // R7: the flag stays low outside detect mode
        if (MODE != ADD_DETECT) a_r7_flag_quiet: assert (ovf_o == 1'b0);
        // R6: operands of opposite sign can never overflow
        if (MODE == ADD_DETECT && SIGNED)
            a_r6_mixed_sign: assert (!(ovf_o && (a_al[AW-1] != b_al[AW-1])));
        // R5: an unsigned overflow makes the wrapped sum fall below an operand
        if (MODE == ADD_DETECT && !SIGNED)
            a_r5_wrap_below: assert (ovf_o == (sum_o < OUT_W'(a_al)));
        // R3: two non-negative signed operands give a non-negative grown sum
        if (MODE == ADD_GROW && SIGNED && !a_al[AW-1] && !b_al[AW-1])
            a_r3_nonneg: assert (sum_o[OUT_W-1] == 1'b0);
    end
endmodule

// File: tb/fxadd_mixed_bench.sv
module fxadd_mixed_bench;
    import fxadd_pkg::*;

    // Operand A: 8 bits, 3 fractional. Operand B: 6 bits, 4 fractional.
    // FRAC = 4, integer part = 5, AW = 9.
    localparam int AW = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [7:0] a;
    logic [5:0] b;
    logic [9:0] s_gs, s_gu;
    logic [8:0] s_ws, s_ds, s_du;
    logic       o_gs, o_gu, o_ws, o_ds, o_du;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    fxadd_mixed #(.SIGNED(1'b1), .MODE(ADD_GROW))   u_fxadd_mixed (.a_i(a), .b_i(b), .sum_o(s_gs), .ovf_o(o_gs));
    fxadd_mixed #(.SIGNED(1'b0), .MODE(ADD_GROW))   u_grow_u      (.a_i(a), .b_i(b), .sum_o(s_gu), .ovf_o(o_gu));
    fxadd_mixed #(.SIGNED(1'b1), .MODE(ADD_WRAP))   u_wrap_s      (.a_i(a), .b_i(b), .sum_o(s_ws), .ovf_o(o_ws));
    fxadd_mixed #(.SIGNED(1'b1), .MODE(ADD_DETECT)) u_det_s       (.a_i(a), .b_i(b), .sum_o(s_ds), .ovf_o(o_ds));
    fxadd_mixed #(.SIGNED(1'b0), .MODE(ADD_DETECT)) u_det_u       (.a_i(a), .b_i(b), .sum_o(s_du), .ovf_o(o_du));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h actual=%0d expected=%0d", req, a, b, act, exp);
        end
    endtask

    function automatic int modp(input int v, input int m);
        return ((v % m) + m) % m;
    endfunction

    task automatic apply(input logic [7:0] av, input logic [5:0] bv);
        int sx, ux, wrapped;
        @(posedge clk);
        a = av;
        b = bv;
        @(negedge clk);
        // exact values in units of 2^-4: A is shifted up by one (R1)
        sx = int'($signed(av)) * 2 + int'($signed(bv));
        ux = int'(av) * 2 + int'(bv);
        chk("R3_grow_signed", int'(s_gs), modp(sx, 1024));
        chk("R3_grow_unsigned", int'(s_gu), ux);
        chk("R4_wrap", int'(s_ws), modp(sx, 512));
        chk("R7_flag_wrap_grow", int'({o_ws, o_gs, o_gu}), 0);
        chk("R6_detect_sum", int'(s_ds), modp(sx, 512));
        chk("R6_detect_flag", int'(o_ds), int'(sx < -256 || sx > 255));
        chk("R5_detect_sum", int'(s_du), modp(ux, 512));
        chk("R5_detect_flag", int'(o_du), int'(ux >= 512));
    endtask

    initial begin
        a = '0;
        b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R7_reset_zero", int'({s_gs, s_ws, o_ds, o_du}), 0);
        // R8: result widths and binary point position
        chk("R8_width_grow", $bits(s_gs), AW + 1);
        chk("R8_width_keep", $bits(s_ds), AW);
        apply(8'd1, 6'd0);
        chk("R8_a_lsb_weight", int'(s_gu), 2);   // A LSB is 2^-3 = two result LSBs
        apply(8'd0, 6'd1);
        chk("R8_b_lsb_weight", int'(s_gu), 1);
        // R2: B = -1/16 sign-extends in signed mode, zero-extends in unsigned
        apply(8'd0, 6'h3f);
        chk("R2_sign_fill", int'(s_gs), 1023);
        chk("R2_zero_fill", int'(s_gu), 63);
        // directed corners
        apply(8'h7f, 6'h1f);   // largest positives: signed overflow
        apply(8'h80, 6'h20);   // most negative: signed overflow
        apply(8'h80, 6'h1f);   // opposite signs
        apply(8'hff, 6'h3f);   // all ones: unsigned carry
        apply(8'h7f, 6'h00);
        apply(8'hc0, 6'h3f);
        begin
            int seed = 32'h5eed_1234;
            void'($urandom(seed));
            for (int i = 0; i < 400; i++) apply(8'($urandom), 6'($urandom));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule